// File: doc/BRIEF.md
# Safeload Coefficient Update Buffer

This block lets a host change a small group of DSP coefficients while audio keeps running, without a click from a half-written filter. The host fills up to five staging slots. Each slot holds a parameter-memory address and a data word. It then arms a trigger. Nothing reaches the parameter memory until the next audio-frame start pulse. From that point the block drains every filled slot into the memory through a request/grant write port that the memory arbiter shares with the DSP core.

The drain runs from the lowest filled slot to the highest. Each write waits for the grant. A filled slot is emptied once its write is granted. While the drain is in progress the block reports busy and ignores every host register write. A host-programmed cycle budget bounds the drain. If the budget runs out, the block stops and raises a one-cycle overrun pulse. The slots not yet written stay filled and the trigger stays armed, so the rest goes out at the next frame start.

Top module: `safeload_buffer`

## Requirements
- R1: After reset, busy, ramReq and overrun are 0, no slot is filled, the trigger is not armed and the cycle budget is DEFAULT_BUDGET.
- R2: A trigger (host write to address 15 with data bit 0 set) never starts a drain by itself. busy rises only on the clock edge that samples frameStart high while armed with at least one filled slot, so it is seen high in the cycle after the frameStart pulse.
- R3: Host address k (0..4) sets slot k's memory address, and host address 8+k sets slot k's data word and marks the slot filled. A drain writes only filled slots, in ascending slot order, each with its own address and data.
- R4: While ramReq is high and ramGrant is low, ramReq, ramAddr and ramData hold steady into the next cycle, unless the budget ends the drain. One write completes in each cycle where ramReq and ramGrant are both high.
- R5: A slot is emptied by its granted write, so a later trigger with no new host data writes nothing.
- R6: While busy is high, every host write is ignored. This covers staging data and the trigger, and a refused trigger does not arm a later drain.
- R7: Host address 14 sets the cycle budget. A drain stays active for at most that many cycles. If it is not done by then, it stops, overrun pulses high for one cycle, and the unwritten slots stay filled and stay armed, then drain in order at the next frameStart.
- R8: busy falls on the same edge that completes the last filled slot's write.
- R9: A frameStart that finds the trigger armed but no slot filled writes nothing, leaves busy low, and disarms the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host register address |
| hostWdata | input | DATA_W | Host write data |
| frameStart | input | 1 | One-cycle audio-frame start pulse |
| ramGrant | input | 1 | Memory arbiter grants the pending write |
| ramReq | output | 1 | Write request to parameter memory |
| ramAddr | output | ADDR_W | Write address |
| ramData | output | DATA_W | Write data |
| busy | output | 1 | Drain in progress |
| overrun | output | 1 | One-cycle pulse: budget ran out before the drain finished |

## Verification
busy is due in the cycle after frameStart. Each granted write shows in the same cycle that ramReq and ramGrant are both high. The fall of busy and the overrun pulse both appear in the cycle after the edge that ends the drain. Inputs change one time unit after a rising edge, and every output is sampled on the falling edge, so each result is read in the cycle it is due. A scoreboard queue holds the expected address/data pairs in slot order, and a monitor pops one for each granted write. It also checks that a stalled request holds its address, and that busy is low in the cycle after the queue empties.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  typedef struct packed {
    logic commit;    // current slot's write granted this cycle
    logic lockHost;  // refuse host writes
  } slStrobe_t;
endpackage

// File: rtl/safeload_datapath.sv
module safeload_datapath
  import safeload_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 28,
  parameter int CNT_W = 16,
  parameter int DEFAULT_BUDGET = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [3:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  slStrobe_t         st,
  output logic              anyValid,
  output logic              lastValid,
  output logic              trigReq,
  output logic [CNT_W-1:0]  budget,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [3:0] DATA_BASE = 4'd8;
  localparam logic [3:0] BUDGET_ADDR = 4'd14;
  localparam logic [3:0] TRIG_ADDR = 4'd15;

  logic [NUM_SLOTS-1:0][ADDR_W-1:0] addrQ;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] dataQ;
  logic [NUM_SLOTS-1:0]             valid;
  logic [IDX_W-1:0]                 curIdx;
  logic                             hostOk;

  assign hostOk = hostWe && !st.lockHost;
  assign trigReq = hostOk && (hostAddr == TRIG_ADDR) && hostWdata[0];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          addrQ[gi] <= '0;
          dataQ[gi] <= '0;
          valid[gi] <= 1'b0;
        end else begin
          if (hostOk && hostAddr == 4'(gi))
            addrQ[gi] <= hostWdata[ADDR_W-1:0];
          if (hostOk && hostAddr == DATA_BASE + 4'(gi)) begin
            dataQ[gi] <= hostWdata;
            valid[gi] <= 1'b1;
          end else if (st.commit && curIdx == IDX_W'(gi)) begin
            valid[gi] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) budget <= CNT_W'(DEFAULT_BUDGET);
    else if (hostOk && hostAddr == BUDGET_ADDR) budget <= hostWdata[CNT_W-1:0];
  end

  // lowest filled slot goes first
  always_comb begin
    curIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (valid[i]) curIdx = IDX_W'(i);
  end

  assign anyValid = |valid;
  assign lastValid = anyValid && ((valid & (valid - 1'b1)) == '0);
  assign ramAddr = addrQ[curIdx];
  assign ramData = dataQ[curIdx];

  // R6: locked staging is untouched by host writes
  a_r6_host_locked: assert property (@(posedge clk) disable iff (!rstN)
    st.lockHost && hostWe |=> $stable(addrQ) && $stable(dataQ) && $stable(budget));
  // R5: a granted slot is empty afterwards
  a_r5_slot_emptied: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> !valid[$past(curIdx)]);
endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
  import safeload_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             ramGrant,
  input  logic             anyValid,
  input  logic             lastValid,
  input  logic             trigReq,
  input  logic [CNT_W-1:0] budget,
  output slStrobe_t        st,
  output logic             ramReq,
  output logic             busy,
  output logic             overrun
);
  logic             armed;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             grantNow;
  logic             finishing;
  logic             timeUp;

  assign ramReq = active && anyValid;
  assign grantNow = ramReq && ramGrant;
  assign finishing = (grantNow && lastValid) || !anyValid;
  assign timeUp = ({1'b0, cnt} + 1'b1) >= {1'b0, budget};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
      active <= 1'b0;
      cnt <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (!active) begin
        if (frameStart && armed) begin
          if (anyValid) begin
            active <= 1'b1;
            cnt <= '0;
          end else begin
            armed <= 1'b0;
          end
        end
        if (trigReq) armed <= 1'b1;
      end else if (finishing) begin
        active <= 1'b0;
        armed <= 1'b0;
      end else if (timeUp) begin
        active <= 1'b0;
        overrun <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign st.commit = grantNow;
  assign st.lockHost = active;
  assign busy = active;

  // R2: a drain only begins on a frame start
  a_r2_start_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(frameStart));
  // R7: the drain never outlives its budget
  a_r7_within_budget: assert property (@(posedge clk) disable iff (!rstN)
    active && budget != '0 |-> cnt < budget);
  // R7: overrun is a single-cycle pulse
  a_r7_overrun_pulse: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> !overrun);
endmodule

// File: rtl/safeload_buffer.sv
module safeload_buffer
  import safeload_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 28,
  parameter int CNT_W = 16,
  parameter int DEFAULT_BUDGET = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [3:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              frameStart,
  input  logic              ramGrant,
  output logic              ramReq,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic              busy,
  output logic              overrun
);
  slStrobe_t        st;
  logic             anyValid;
  logic             lastValid;
  logic             trigReq;
  logic [CNT_W-1:0] budget;

  safeload_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .DEFAULT_BUDGET(DEFAULT_BUDGET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .st(st), .anyValid(anyValid),
    .lastValid(lastValid), .trigReq(trigReq), .budget(budget),
    .ramAddr(ramAddr), .ramData(ramData)
  );

  safeload_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .ramGrant(ramGrant),
    .anyValid(anyValid), .lastValid(lastValid), .trigReq(trigReq),
    .budget(budget), .st(st), .ramReq(ramReq), .busy(busy),
    .overrun(overrun)
  );

  // R4: a stalled request keeps its address and data
  a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    ramReq && !ramGrant |=> overrun || (ramReq && $stable(ramAddr) && $stable(ramData)));
  // R3: requests only appear during a drain
  a_r3_req_in_drain: assert property (@(posedge clk) disable iff (!rstN)
    ramReq |-> busy);
endmodule

// File: tb/safeload_buffer_tb.sv
module safeload_buffer_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 28;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostWe = 1'b0;
  logic [3:0]        hostAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic              frameStart = 1'b0;
  logic              ramGrant = 1'b0;
  logic              ramReq;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramData;
  logic              busy;
  logic              overrun;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  int grantMode = 0; // 0 always, 1 toggle, 2 never
  logic [ADDR_W+DATA_W-1:0] expQ[$];

  always #4 clk = ~clk;

  safeload_buffer u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .frameStart(frameStart), .ramGrant(ramGrant),
    .ramReq(ramReq), .ramAddr(ramAddr), .ramData(ramData), .busy(busy),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (grantMode)
      0: ramGrant = 1'b1;
      1: ramGrant = ~ramGrant;
      default: ramGrant = 1'b0;
    endcase
  end

  // monitor / scoreboard
  logic              prevStall = 1'b0;
  logic [ADDR_W-1:0] stallAddr = '0;
  logic              lastCk = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (lastCk) check(busy == 1'b0, "R8 busy low after last write", busy, 0);
      lastCk = 1'b0;
      if (prevStall && ramReq)
        check(ramAddr == stallAddr, "R4 stalled address held", ramAddr, stallAddr);
      if (ramReq && ramGrant) begin
        writes++;
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected RAM write", {ramAddr, ramData}, 0);
        end else begin
          logic [ADDR_W+DATA_W-1:0] e;
          e = expQ.pop_front();
          check({ramAddr, ramData} == e, "R3 RAM write addr/data", {ramAddr, ramData}, e);
          if (expQ.size() == 0) lastCk = 1'b1;
        end
      end
      prevStall = ramReq && !ramGrant;
      stallAddr = ramAddr;
    end
  end

  task automatic hostWr(input logic [3:0] a, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic stage(input int k, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    hostWr(4'(k), DATA_W'(a));
    hostWr(4'(8 + k), d);
  endtask

  task automatic frame();
    @(posedge clk); #1; frameStart = 1'b1;
    @(posedge clk); #1; frameStart = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 500);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(ramReq == 0, "R1 ramReq after reset", ramReq, 0);
    check(overrun == 0, "R1 overrun after reset", overrun, 0);

    // R2/R3: sparse slots 0,2,4
    grantMode = 0;
    hostWr(4'd14, 100);
    stage(0, 10'h011, 28'h0A00001);
    stage(2, 10'h022, 28'h0A00002);
    stage(4, 10'h044, 28'h0A00004);
    hostWr(4'd15, 1);
    repeat (5) @(negedge clk);
    check(busy == 0 && ramReq == 0, "R2 no drain before frame", busy, 0);
    expQ.push_back({10'h011, 28'h0A00001});
    expQ.push_back({10'h022, 28'h0A00002});
    expQ.push_back({10'h044, 28'h0A00004});
    frame();
    @(negedge clk);
    check(busy == 1, "R2 busy after frameStart", busy, 1);
    waitIdle();
    check(expQ.size() == 0, "R3 all filled slots written", expQ.size(), 0);
    check(writes == 3, "R3 write count", writes, 3);

    // R4: stalled grants
    grantMode = 1;
    stage(1, 10'h101, 28'h0B00001);
    stage(3, 10'h303, 28'h0B00003);
    hostWr(4'd15, 1);
    expQ.push_back({10'h101, 28'h0B00001});
    expQ.push_back({10'h303, 28'h0B00003});
    frame();
    waitIdle();
    check(writes == 5, "R4 writes under toggling grant", writes, 5);

    // R5/R9: trigger with nothing filled
    grantMode = 0;
    w0 = writes;
    hostWr(4'd15, 1);
    frame();
    @(negedge clk);
    check(busy == 0, "R9 busy stays low with no slots", busy, 0);
    repeat (8) @(negedge clk);
    check(writes == w0, "R5 emptied slots not rewritten", writes, w0);

    // R6: host writes refused while busy
    grantMode = 2;
    for (int k = 0; k < 5; k++) stage(k, 10'(10'h200 + k), 28'(28'h0C00000 + k));
    hostWr(4'd15, 1);
    for (int k = 0; k < 5; k++) expQ.push_back({10'(10'h200 + k), 28'(28'h0C00000 + k)});
    frame();
    @(negedge clk);
    check(busy == 1, "R6 busy during stalled drain", busy, 1);
    hostWr(4'd8, 28'hFFFFFFF);
    hostWr(4'd0, 28'h3FF);
    hostWr(4'd15, 1);
    grantMode = 0;
    waitIdle();
    check(writes == w0 + 5, "R6 original data drained", writes, w0 + 5);
    w0 = writes;
    frame();
    repeat (8) @(negedge clk);
    check(writes == w0, "R6 refused trigger did not arm", writes, w0);

    // R7: budget of 3 cycles with five slots
    hostWr(4'd14, 3);
    for (int k = 0; k < 5; k++) stage(k, 10'(10'h300 + k), 28'(28'h0D00000 + k));
    hostWr(4'd15, 1);
    for (int k = 0; k < 5; k++) expQ.push_back({10'(10'h300 + k), 28'(28'h0D00000 + k)});
    frame();
    waitIdle();
    check(overrun == 1, "R7 overrun pulse when budget ends", overrun, 1);
    check(expQ.size() == 2, "R7 three writes in budget", expQ.size(), 2);
    @(negedge clk);
    check(overrun == 0, "R7 overrun lasts one cycle", overrun, 0);
    frame();
    waitIdle();
    check(expQ.size() == 0, "R7 remainder drained next frame", expQ.size(), 0);
    check(overrun == 0, "R7 no overrun when within budget", overrun, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule